// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture Core

This block is the acquisition engine of a multi-channel logic analyzer. A host sets a trigger mode, a serial pattern with its bit mask, a parallel pattern with its per-channel mask, a channel to watch and a number of points, then pulses `start`. From then on, every cycle with `samp_en` high stores the current channel word to an external synchronous SRAM at consecutive addresses starting at 0. The configured number of points ends the capture and raises `done`.

While capturing, the block looks for a trigger. There are three kinds. The immediate trigger fires at the start itself. The sequential trigger matches the last eight values seen on one selected channel against a serial pattern. The parallel trigger matches all channels of the current sample at once against a word. The first match sets `trig_flag` and latches the address of the sample that completed it. Later matches in the same capture change nothing.

After the capture, the host pulses `rd_start` and then steps through memory with `rd_strobe`. Each step returns one stored word on `rd_data` one cycle later, with `rd_valid` high.

Top module: `la_capture`

## Requirements
- R1: After reset, `busy`, `done`, `trig_flag`, `sram_we` and `rd_valid` are 0 and `trig_pos` is 0.
- R2: While `busy` is high, each cycle with `samp_en` high drives `sram_we` high in that same cycle. In that cycle `sram_addr` holds the sample index, counted from 0 since `start`, and `sram_wdata` holds `ch_in`.
- R3: When the sample with index `num_pts`-1 is written, `busy` falls and `done` rises on the next edge, and later `samp_en` pulses write nothing. If `num_pts` is 0, `done` rises right after `start` and nothing is written.
- R4: Mode 2'b00 (immediate) sets `trig_flag` on the edge that takes `start`, with `trig_pos` equal to 0.
- R5: Mode 2'b01 (sequential) shifts bit `chan_sel` of each sample into an 8-bit history, with the newest bit in bit 0 and the oldest in bit 7. The trigger fires when `((history ^ seq_word) & seq_mask) == 0`.
- R6: The sequential trigger cannot fire before the eighth sample of a capture.
- R7: Mode 2'b10 (parallel) fires when `((ch_in ^ par_word) & par_mask) == 0` for the current sample.
- R8: A mask bit of 0 removes that bit from the comparison. With an all-zero mask, the sequential trigger fires on the eighth sample and the parallel trigger fires on the first sample.
- R9: On the first match, `trig_pos` latches the address of the matching sample. Later matches in the same capture leave `trig_flag` and `trig_pos` unchanged.
- R10: A capture that ends without a match still raises `done`, and `trig_flag` stays 0.
- R11: A `start` pulse clears `done` and `trig_flag` (except in immediate mode) and restarts writing at address 0, even in the middle of a capture.
- R12: `rd_start` resets the read address to 0. Each `rd_strobe` while not `busy` reads the next address and presents the word on `rd_data` with `rd_valid` high one cycle later. Strobes while `busy` are ignored.
- R13: Mode 2'b11 is disarmed and never raises `trig_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a capture (pulse) |
| mode | input | 2 | 00 immediate, 01 sequential, 10 parallel, 11 disarmed |
| chan_sel | input | $clog2(NCH) | Channel watched by the sequential trigger |
| seq_word | input | 8 | Serial pattern, bit 7 oldest |
| seq_mask | input | 8 | Serial pattern care bits |
| par_word | input | NCH | Parallel pattern |
| par_mask | input | NCH | Parallel pattern care bits |
| num_pts | input | AW+1 | Number of samples to store |
| samp_en | input | 1 | Sampling strobe |
| ch_in | input | NCH | Channel inputs |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | AW | SRAM address |
| sram_wdata | output | NCH | SRAM write data |
| sram_rdata | input | NCH | SRAM read data, one cycle after address |
| rd_start | input | 1 | Host read command, rewinds read address |
| rd_strobe | input | 1 | Host read step |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_data | output | NCH | Read-back word |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished |
| trig_flag | output | 1 | Trigger seen in this capture |
| trig_pos | output | AW | Address of the triggering sample |

## Verification
The bench places the serial pattern on one channel and puts the complement on every other channel. A design that reads the wrong channel, or shifts the history the wrong way, therefore reports the wrong position or no trigger at all. A second occurrence of each pattern follows the first, so a design that re-latches on every match shows a later `trig_pos`. An all-zero serial mask would fire on a history still being filled; here it must fire at index 7 and not sooner. A zero point count, a restart in the middle of a capture, and read strobes while busy cover a counter that wraps, a pointer that is not cleared, and a read that disturbs the capture.

// File: rtl/la_capture.sv
module la_capture #(
  parameter int NCH = 8,
  parameter int AW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             mode,
  input  logic [$clog2(NCH)-1:0] chan_sel,
  input  logic [7:0]             seq_word,
  input  logic [7:0]             seq_mask,
  input  logic [NCH-1:0]         par_word,
  input  logic [NCH-1:0]         par_mask,
  input  logic [AW:0]            num_pts,
  input  logic                   samp_en,
  input  logic [NCH-1:0]         ch_in,
  output logic                   sram_we,
  output logic [AW-1:0]          sram_addr,
  output logic [NCH-1:0]         sram_wdata,
  input  logic [NCH-1:0]         sram_rdata,
  input  logic                   rd_start,
  input  logic                   rd_strobe,
  output logic                   rd_valid,
  output logic [NCH-1:0]         rd_data,
  output logic                   busy,
  output logic                   done,
  output logic                   trig_flag,
  output logic [AW-1:0]          trig_pos
);
  localparam logic [AW:0]   CNT_ONE = (AW+1)'(1);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  logic [AW:0]   cnt;
  logic [AW-1:0] rptr;
  logic [7:0]    hist;
  logic [3:0]    fill;
  logic          hit;

  wire           take    = busy & samp_en;
  wire [7:0]     hist_nx = {hist[6:0], ch_in[chan_sel]};
  wire           seq_hit = (fill >= 4'd7) && (((hist_nx ^ seq_word) & seq_mask) == 8'h00);
  wire           par_hit = ((ch_in ^ par_word) & par_mask) == '0;
  wire           last    = (cnt + CNT_ONE) == num_pts;
  wire [AW-1:0]  rbase   = rd_start ? '0 : rptr;
  wire           rd_go   = rd_strobe & ~busy;

  always_comb begin
    case (mode)
      2'b01:   hit = seq_hit;
      2'b10:   hit = par_hit;
      default: hit = 1'b0;
    endcase
  end

  assign sram_we    = take;
  assign sram_wdata = ch_in;
  assign sram_addr  = busy ? cnt[AW-1:0] : rbase;
  assign rd_data    = sram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rptr      <= '0;
      hist      <= '0;
      fill      <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      trig_flag <= 1'b0;
      trig_pos  <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_start | rd_go)
        rptr <= rd_go ? rbase + PTR_ONE : rbase;
      if (start) begin
        busy      <= num_pts != '0;
        done      <= num_pts == '0;
        cnt       <= '0;
        hist      <= '0;
        fill      <= '0;
        trig_flag <= mode == 2'b00;
        trig_pos  <= '0;
      end else if (take) begin
        cnt  <= cnt + CNT_ONE;
        hist <= hist_nx;
        if (fill != 4'd8) fill <= fill + 4'd1;
        if (hit && !trig_flag) begin
          trig_flag <= 1'b1;
          trig_pos  <= cnt[AW-1:0];
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

module la_capture_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    mode,
  input logic          sram_we,
  input logic [AW-1:0] sram_addr,
  input logic          busy,
  input logic          done,
  input logic          trig_flag,
  input logic [AW-1:0] trig_pos
);
  // R2
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> busy);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && !start) |=> (!busy || sram_addr == $past(sram_addr) + 1'b1));

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R4
  imm_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'b00) |=> (trig_flag && trig_pos == '0));

  // R9
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_flag && !start) |=> (trig_flag && $stable(trig_pos)));

  // R11
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode != 2'b00) |=> !trig_flag);

  // R13
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !trig_flag && !start) |=> !trig_flag);
endmodule

bind la_capture la_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
  .sram_we(sram_we), .sram_addr(sram_addr), .busy(busy), .done(done),
  .trig_flag(trig_flag), .trig_pos(trig_pos)
);

// File: tb/la_capture_tb.sv
`timescale 1ns/1ps
module la_capture_tb;
  localparam int NCH = 8;
  localparam int AW  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, samp_en = 1'b0;
  logic rd_start = 1'b0, rd_strobe = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] chan_sel = '0;
  logic [7:0] seq_word = '0, seq_mask = '0;
  logic [NCH-1:0] par_word = '0, par_mask = '0, ch_in = '0;
  logic [AW:0] num_pts = '0;
  logic sram_we, rd_valid, busy, done, trig_flag;
  logic [AW-1:0] sram_addr, trig_pos;
  logic [NCH-1:0] sram_wdata, rd_data;
  logic [NCH-1:0] sram_rdata = '0;
  logic [NCH-1:0] mem [1<<AW];
  int wr_cnt = 0;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (sram_we) begin
      mem[sram_addr] <= sram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    sram_rdata <= mem[sram_addr];
  end

  la_capture #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .chan_sel(chan_sel),
    .seq_word(seq_word), .seq_mask(seq_mask), .par_word(par_word), .par_mask(par_mask),
    .num_pts(num_pts), .samp_en(samp_en), .ch_in(ch_in), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .rd_start(rd_start), .rd_strobe(rd_strobe), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .trig_flag(trig_flag), .trig_pos(trig_pos)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [1:0] m, input int n);
    @(negedge clk);
    mode = m; num_pts = (AW+1)'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic sample(input logic [7:0] d);
    @(negedge clk);
    samp_en = 1'b1; ch_in = d;
    @(negedge clk);
    samp_en = 1'b0;
  endtask

  task automatic rd_rewind();
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
  endtask

  task automatic rd_one(input logic [7:0] exp, input string req);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    chk(rd_valid == 1'b1, req, rd_valid, 1);
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1", {busy, done}, 0);
    chk(!trig_flag && trig_pos == 0, "R1", {trig_flag, trig_pos}, 0);
    chk(!sram_we && !rd_valid, "R1", {sram_we, rd_valid}, 0);
  endtask

  task automatic t_immediate();
    logic [7:0] d [5] = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'h5A};
    int w0;
    go(2'b00, 5);
    chk(trig_flag && trig_pos == 0, "R4", {trig_flag, trig_pos}, 9'h100);
    chk(busy && !done, "R2", {busy, done}, 2);
    w0 = wr_cnt;
    for (int i = 0; i < 5; i++) sample(d[i]);
    chk(wr_cnt - w0 == 5, "R2", wr_cnt - w0, 5);
    chk(done && !busy, "R3", {busy, done}, 1);
    sample(8'hEE);
    chk(wr_cnt - w0 == 5, "R3", wr_cnt - w0, 5);
    rd_rewind();
    for (int i = 0; i < 5; i++) rd_one(d[i], "R12");
    rd_rewind();
    rd_one(d[0], "R12");
  endtask

  task automatic t_seq();
    logic [7:0] p = 8'b1011_0010;
    logic s;
    mode = 2'b01; chan_sel = 3'd3; seq_word = p; seq_mask = 8'hFF;
    go(2'b01, 20);
    for (int i = 0; i < 20; i++) begin
      if (i < 4) s = 1'b0;
      else if (i < 12) s = p[7-(i-4)];
      else s = p[7-(i-12)];
      sample(s ? 8'h08 : 8'hF7);
      if (i == 10) chk(!trig_flag, "R5", trig_flag, 0);
    end
    chk(trig_flag && trig_pos == 11, "R5", trig_pos, 11);
    chk(trig_pos == 11, "R9", trig_pos, 11);
    chk(done, "R3", done, 1);
  endtask

  task automatic t_seq_nomask();
    seq_word = 8'hFF; seq_mask = 8'h00;
    go(2'b01, 10);
    for (int i = 0; i < 10; i++) begin
      sample(8'h00);
      if (i == 6) chk(!trig_flag, "R6", trig_flag, 0);
    end
    chk(trig_flag && trig_pos == 7, "R8", trig_pos, 7);
  endtask

  task automatic t_par();
    par_word = 8'hA5; par_mask = 8'hF0;
    go(2'b10, 4);
    sample(8'h15);
    chk(!trig_flag, "R7", trig_flag, 0);
    sample(8'hA0);
    chk(trig_flag && trig_pos == 1, "R7", trig_pos, 1);
    sample(8'h3C);
    sample(8'hAF);
    chk(trig_flag && trig_pos == 1, "R9", trig_pos, 1);
    par_mask = 8'h00;
    go(2'b10, 2);
    sample(8'h77);
    chk(trig_flag && trig_pos == 0, "R8", trig_pos, 0);
    sample(8'h11);
  endtask

  task automatic t_notrig();
    par_word = 8'hFF; par_mask = 8'hFF;
    go(2'b10, 3);
    for (int i = 0; i < 3; i++) sample(8'h00);
    chk(done && !trig_flag, "R10", {done, trig_flag}, 2);
    par_mask = 8'h00;
    go(2'b11, 3);
    for (int i = 0; i < 3; i++) sample(8'h42);
    chk(done && !trig_flag, "R13", {done, trig_flag}, 2);
  endtask

  task automatic t_restart();
    par_word = 8'hFF; par_mask = 8'hFF;
    go(2'b10, 6);
    sample(8'hFF);
    sample(8'h00);
    chk(trig_flag, "R11", trig_flag, 1);
    go(2'b11, 3);
    chk(busy && !done && !trig_flag, "R11", {busy, done, trig_flag}, 4);
    sample(8'h11);
    sample(8'h22);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    chk(!rd_valid, "R12", rd_valid, 0);
    sample(8'h33);
    chk(done && !busy, "R3", {busy, done}, 1);
    rd_rewind();
    rd_one(8'h11, "R11");
    rd_one(8'h22, "R11");
    rd_one(8'h33, "R11");
  endtask

  task automatic t_zero();
    int w0;
    go(2'b10, 0);
    chk(done && !busy, "R3", {busy, done}, 1);
    w0 = wr_cnt;
    sample(8'h99);
    chk(wr_cnt == w0, "R3", wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_seq();
    t_seq_nomask();
    t_par();
    t_notrig();
    t_restart();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule